// File: doc/BRIEF.md
# Write-Only I2C Control Register Target

This block is an I2C target that only accepts writes. It fills a bank of sixteen 8-bit control registers. SCL and SDA are sampled on the system clock. Each line passes through a synchroniser and a stability filter, so spikes shorter than a set number of system cycles never reach the protocol logic. The protocol engine finds START, repeated START and STOP. It compares the first byte with a fixed address byte that includes the write bit, and it acknowledges by pulling SDA low. After the address byte the engine takes bytes in pairs: first a sub-address byte, then a data byte.

The low nibble of each sub-address picks one of the sixteen registers, and the upper nibble is ignored. The data byte is written into the picked register on the acknowledge clock. The controller may chain any number of sub-address/data pairs before it sends STOP. A byte with a wrong address, or with the read bit set, is not acknowledged, and the block then stays quiet until the next START or STOP. All registers are presented in parallel on one flat output bus. Register k occupies bits 8k+7 down to 8k.

Top module: `i2cw_target`

## Requirements
- R1: After synchronous reset every register reads 0x00 and `sda_pull` is 0.
- R2: With `ALT_ADDR`=0 the address byte 0x36 (7-bit 0x1B, write bit 0) is acknowledged: `sda_pull` is 1 while SCL is high in the ninth clock. With `ALT_ADDR`=1 the acknowledged byte is 0x34 instead.
- R3: An address byte other than the selected one is not acknowledged. This includes the read form 0x37. After such a byte no later byte is acknowledged and no register changes until the next START or STOP.
- R4: Only bits 3..0 of the sub-address select the register (0..15), and bits 7..4 have no effect. At most one register is written per system cycle.
- R5: Bytes arrive MSB first over eight SCL clocks. The data byte is written into the selected register on the rising edge of its ninth (acknowledge) clock, and only if that byte was acknowledged.
- R6: Several sub-address/data pairs may follow one address byte before STOP. Every pair is acknowledged and written.
- R7: A repeated START returns the engine to address reception. A sub-address that was received without its data byte writes nothing.
- R8: A START or STOP inside a byte aborts that byte, and no register is written from it.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_CYC` system cycles is ignored. It neither adds a bit nor creates a START or STOP.
- R10: An SDA change that lands in the same system cycle as an SCL falling edge counts as data hold, not as a START or STOP.
- R11: `sda_pull` is asserted only in the acknowledge slot of an accepted byte. It is never asserted while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (nominal 50 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level (wired bus value) |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain acknowledge) |
| regs_flat | output | 128 | All sixteen registers, register k at bits 8k+7..8k |

## Verification
Both filtered lines run through identical pipelines. As a result, an SCL falling edge and an SDA transition that the controller drives at the same instant reach the engine in the same system cycle. If the engine treated that as a condition, it would drop the transaction. The bench provokes this with a transaction that changes SDA together with every SCL fall, including the release after the acknowledge slot. The case passes only if the engine treats it as an ordinary bit boundary: the byte must be acknowledged and the target register must hold the written value afterwards. The second case that shares a cycle is a commit followed at once by a STOP or a repeated START. It is judged by the register value once the transaction has ended.

// File: rtl/i2cw_pkg.sv
// Package: shared constants and the phase encoding of the write-only I2C target.
package i2cw_pkg;
    localparam int BYTE_W = 8;

    // Which byte of the transaction the engine is receiving.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_SUB  = 2'd2,
        PH_DATA = 2'd3
    } phase_t;
endpackage

// File: rtl/i2cw_deglitch.sv
// Module: i2cw_deglitch
// Purpose: two-flop synchroniser followed by a stability filter. The clean
//          output takes a new level only after the synchronised input has
//          differed from it for FILT_CYC consecutive system cycles.
// Assumes: the idle bus level is high; reset is synchronous and active low.
module i2cw_deglitch #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CNT_W = $clog2(FILT_CYC + 1);

    logic             meta_q;
    logic             sync_q;
    logic [CNT_W-1:0] run_q;

    // Bring the raw line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
        end
    end

    // Count cycles of disagreement and accept the new level once it has lasted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b1;
            run_q <= '0;
        end else if (sync_q == clean) begin
            run_q <= '0;
        end else if (run_q == CNT_W'(FILT_CYC - 1)) begin
            clean <= sync_q;
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // A change of the clean level must follow the synchronised value it accepted.
    AST_FILT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (clean != $past(clean)) |-> (clean == $past(sync_q))); // R9
endmodule

// File: rtl/i2cw_engine.sv
// Module: i2cw_engine
// Purpose: bit-level I2C write protocol on filtered SCL/SDA. It detects the
//          bus conditions, shifts in bytes and drives the acknowledge, and it
//          emits one write strobe per accepted data byte.
// Assumes: inputs are already synchronised and deglitched; SCL is never
//          stretched; read transfers are refused by not acknowledging them.
module i2cw_engine
    import i2cw_pkg::*;
#(
    parameter logic [7:0] ADDR_BYTE = 8'h36,
    parameter int         IDX_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl,
    input  logic              sda,
    output logic              ack_pull,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    localparam logic [3:0] LAST_BIT = 4'd8;
    localparam logic [3:0] ACK_SLOT = 4'd9;

    logic              scl_q, sda_q;
    logic              start_c, stop_c, scl_rise, scl_fall;
    phase_t            phase_q;
    logic [3:0]        bit_q;
    logic [BYTE_W-1:0] shift_q;
    logic [IDX_W-1:0]  idx_q;

    // Keep the previous filtered levels for edge and condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Decode the bus events; a condition needs SCL high in both cycles.
    always_comb begin
        start_c  = scl & scl_q & sda_q & ~sda;
        stop_c   = scl & scl_q & ~sda_q & sda;
        scl_rise = scl & ~scl_q;
        scl_fall = ~scl & scl_q;
    end

    // Protocol sequencer: shift bits, decide the acknowledge, commit data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            bit_q    <= '0;
            shift_q  <= '0;
            idx_q    <= '0;
            ack_pull <= 1'b0;
            wr_en    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (start_c) begin
                phase_q  <= PH_ADDR;
                bit_q    <= '0;
                ack_pull <= 1'b0;
            end else if (stop_c) begin
                phase_q  <= PH_IDLE;
                bit_q    <= '0;
                ack_pull <= 1'b0;
            end else if (phase_q != PH_IDLE) begin
                if (scl_rise) begin
                    if (bit_q < LAST_BIT) begin
                        shift_q <= {shift_q[BYTE_W-2:0], sda};
                        bit_q   <= bit_q + 1'b1;
                    end else if (bit_q == ACK_SLOT && phase_q == PH_DATA && ack_pull) begin
                        wr_en <= 1'b1;
                    end
                end else if (scl_fall) begin
                    if (bit_q == LAST_BIT) begin
                        case (phase_q)
                            PH_ADDR: begin
                                if (shift_q == ADDR_BYTE) begin
                                    ack_pull <= 1'b1;
                                    bit_q    <= ACK_SLOT;
                                end else begin
                                    phase_q <= PH_IDLE;
                                    bit_q   <= '0;
                                end
                            end
                            PH_SUB: begin
                                idx_q    <= shift_q[IDX_W-1:0];
                                ack_pull <= 1'b1;
                                bit_q    <= ACK_SLOT;
                            end
                            default: begin
                                ack_pull <= 1'b1;
                                bit_q    <= ACK_SLOT;
                            end
                        endcase
                    end else if (bit_q == ACK_SLOT) begin
                        ack_pull <= 1'b0;
                        bit_q    <= '0;
                        phase_q  <= (phase_q == PH_SUB) ? PH_DATA : PH_SUB;
                    end
                end
            end
        end
    end

    assign wr_idx  = idx_q;
    assign wr_data = shift_q;

    AST_WRITE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(ack_pull)); // R5
    AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE) |-> !ack_pull); // R11
    AST_COND_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        start_c |=> (phase_q == PH_ADDR && bit_q == 4'd0 && !ack_pull)); // R7
    AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> (phase_q == PH_IDLE && !wr_en)); // R8
endmodule

// File: rtl/i2cw_target.sv
// Module: i2cw_target
// Purpose: top of the write-only I2C register target. It filters both bus
//          lines, runs the protocol engine and holds the register bank.
// Assumes: sda_in is the wired bus value; sda_pull drives an external
//          open-drain pull-down; NREG is a power of two no larger than 16.
module i2cw_target
    import i2cw_pkg::*;
#(
    parameter bit ALT_ADDR = 1'b0,
    parameter int FILT_CYC = 3,
    parameter int NREG     = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_pull,
    output logic [NREG*BYTE_W-1:0] regs_flat
);
    localparam int         IDX_W     = $clog2(NREG);
    localparam logic [7:0] ADDR_BYTE = ALT_ADDR ? 8'h34 : 8'h36;

    logic [1:0]        raw_lines;
    logic [1:0]        clean_lines;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [NREG-1:0]   we_vec;

    assign raw_lines = {sda_in, scl_in};

    // One identical filter per bus line keeps the two paths aligned in time.
    for (genvar ln = 0; ln < 2; ln++) begin : g_filt
        i2cw_deglitch #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_lines[ln]),
            .clean(clean_lines[ln])
        );
    end

    i2cw_engine #(.ADDR_BYTE(ADDR_BYTE), .IDX_W(IDX_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl     (clean_lines[0]),
        .sda     (clean_lines[1]),
        .ack_pull(sda_pull),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    // Register bank: each register loads when its decoded strobe fires.
    for (genvar r = 0; r < NREG; r++) begin : g_reg
        assign we_vec[r] = wr_en && (wr_idx == IDX_W'(r));

        // Hold or load one control register.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_flat[r*BYTE_W +: BYTE_W] <= '0;
            end else if (we_vec[r]) begin
                regs_flat[r*BYTE_W +: BYTE_W] <= wr_data;
            end
        end
    end

    AST_ONE_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec)); // R4
endmodule

// File: tb/i2cw_target_tb.sv
module i2cw_target_tb;
    localparam int HALF = 60;  // SCL half period in system cycles (about 400 kHz)
    localparam int FILT = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic         sda_pull;
    logic [127:0] regs_flat;
    wire          sda_line = sda_m & ~sda_pull;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_regs [16];

    i2cw_target #(.ALT_ADDR(1'b0), .FILT_CYC(FILT), .NREG(16)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_m),
        .sda_in   (sda_line),
        .sda_pull (sda_pull),
        .regs_flat(regs_flat)
    );

    always #10 clk = ~clk;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_bank(input string req);
        for (int r = 0; r < 16; r++) check(req, 32'(regs_flat[r*8 +: 8]), 32'(exp_regs[r]));
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF/2);
        sda_m = 1'b0; wait_cyc(HALF/2);
        scl_m = 1'b0; wait_cyc(HALF/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF/2);
        sda_m = 1'b1; wait_cyc(HALF);
    endtask

    // Send bits; tight=1 changes SDA at the same instant SCL falls.
    task automatic send_bits(input logic [7:0] b, input int nbits, input bit tight);
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!tight || i == 7) sda_m = b[i];
            wait_cyc(HALF/2);
            scl_m = 1'b1; wait_cyc(HALF);
            scl_m = 1'b0;
            if (tight) sda_m = (i == 0) ? 1'b1 : b[i-1];
            wait_cyc(HALF/2);
        end
    endtask

    // Full byte plus ninth clock; returns the bus level seen in the ACK slot.
    task automatic send_byte(input logic [7:0] b, input bit tight, output logic ack_lvl);
        send_bits(b, 8, tight);
        sda_m = 1'b1; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF/2);
        ack_lvl = sda_line;
        wait_cyc(HALF/2);
        scl_m = 1'b0; wait_cyc(HALF/2);
    endtask

    task automatic write_pair(input logic [7:0] sub, input logic [7:0] data, input string req);
        logic a;
        send_byte(sub, 1'b0, a);  check(req, 32'(a), 32'd0);
        send_byte(data, 1'b0, a); check(req, 32'(a), 32'd0);
        exp_regs[sub[3:0]] = data;
    endtask

    task automatic t_reset();
        check("R1", 32'(sda_pull), 32'd0);
        check_bank("R1");
    endtask

    task automatic t_basic();
        logic a;
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R2 ack addr", 32'(a), 32'd0);
        write_pair(8'h02, 8'hA5, "R5");
        bus_stop();
        check_bank("R5");
    endtask

    task automatic t_upper_nibble();
        logic a;
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R2", 32'(a), 32'd0);
        write_pair(8'hF3, 8'h5A, "R4");
        write_pair(8'h9F, 8'h81, "R4");
        bus_stop();
        check_bank("R4");
    endtask

    task automatic t_chain();
        logic a;
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R6", 32'(a), 32'd0);
        for (int k = 0; k < 6; k++) write_pair(8'(k + 4), 8'(8'h10 * k + 8'h07), "R6");
        bus_stop();
        check_bank("R6");
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'h37, 1'b0, a); check("R3 read nack", 32'(a), 32'd1);
        send_byte(8'h01, 1'b0, a); check("R3 quiet", 32'(a), 32'd1);
        send_byte(8'hEE, 1'b0, a); check("R3 quiet", 32'(a), 32'd1);
        bus_stop();
        bus_start();
        send_byte(8'h34, 1'b0, a); check("R3 alt nack", 32'(a), 32'd1);
        send_byte(8'h02, 1'b0, a); check("R3 quiet", 32'(a), 32'd1);
        send_byte(8'h33, 1'b0, a); check("R3 quiet", 32'(a), 32'd1);
        bus_stop();
        check_bank("R3");
        check("R11 idle", 32'(sda_pull), 32'd0);
    endtask

    task automatic t_restart();
        logic a;
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R7", 32'(a), 32'd0);
        write_pair(8'h0A, 8'h11, "R7");
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R7 readdr", 32'(a), 32'd0);
        send_byte(8'h0B, 1'b0, a); check("R7", 32'(a), 32'd0);
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R7 readdr", 32'(a), 32'd0);
        write_pair(8'h0C, 8'h22, "R7");
        bus_stop();
        check_bank("R7");
    endtask

    task automatic t_abort();
        logic a;
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R8", 32'(a), 32'd0);
        send_byte(8'h05, 1'b0, a); check("R8", 32'(a), 32'd0);
        send_bits(8'hC3, 4, 1'b0);
        bus_stop();
        check_bank("R8 stop");
        bus_start();
        send_byte(8'h36, 1'b0, a);
        send_byte(8'h05, 1'b0, a);
        send_bits(8'h3C, 5, 1'b0);
        bus_start();
        send_byte(8'h36, 1'b0, a); check("R8 after start", 32'(a), 32'd0);
        write_pair(8'h0D, 8'h6B, "R8");
        bus_stop();
        check_bank("R8 start");
    endtask

    task automatic t_glitch();
        logic a;
        // SDA spike low while the bus idles: must not look like START.
        wait_cyc(HALF);
        sda_m = 1'b0; wait_cyc(FILT - 1); sda_m = 1'b1;
        wait_cyc(HALF);
        check("R9 no false start", 32'(sda_pull), 32'd0);
        bus_start();
        // Address byte with short SCL spikes inside high and low phases.
        for (int i = 7; i >= 0; i--) begin
            sda_m = 8'h36 >> i;
            wait_cyc(HALF/4);
            scl_m = 1'b1; wait_cyc(FILT - 1); scl_m = 1'b0;
            wait_cyc(HALF/4);
            scl_m = 1'b1; wait_cyc(HALF/2);
            scl_m = 1'b0; wait_cyc(FILT - 1); scl_m = 1'b1;
            wait_cyc(HALF/2);
            scl_m = 1'b0; wait_cyc(HALF/2);
        end
        sda_m = 1'b1; wait_cyc(HALF/2);
        scl_m = 1'b1; wait_cyc(HALF/2);
        a = sda_line;
        wait_cyc(HALF/2);
        scl_m = 1'b0; wait_cyc(HALF/2);
        check("R9 ack", 32'(a), 32'd0);
        write_pair(8'h0E, 8'hC7, "R9");
        bus_stop();
        check_bank("R9");
    endtask

    task automatic t_tight();
        logic a;
        bus_start();
        send_byte(8'h36, 1'b1, a); check("R10 ack", 32'(a), 32'd0);
        send_byte(8'h00, 1'b1, a); check("R10 ack", 32'(a), 32'd0);
        send_byte(8'h96, 1'b1, a); check("R10 ack", 32'(a), 32'd0);
        exp_regs[0] = 8'h96;
        send_byte(8'h01, 1'b1, a); check("R10 ack", 32'(a), 32'd0);
        send_byte(8'h3E, 1'b1, a); check("R10 ack", 32'(a), 32'd0);
        exp_regs[1] = 8'h3E;
        bus_stop();
        check_bank("R10");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        wait_cyc(150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < 16; r++) exp_regs[r] = 8'h00;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
        t_reset();
        t_basic();
        t_upper_nibble();
        t_chain();
        t_bad_addr();
        t_restart();
        t_abort();
        t_glitch();
        t_tight();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule